// File: doc/BRIEF.md
# Grouped Interrupt Combiner Bank

This block gathers a vector of level-sensitive interrupt sources and folds them into a small number of group lines for a parent interrupt controller. The sources are split into equal byte-wide groups. Each source has one enable bit. A group line is high while at least one enabled source in its byte is high. Nothing needs to be acknowledged: a line falls once its enabled sources fall or are disabled.

Software works through a 32-bit register port with address, write enable, write data and read data. Enable bits are never written directly. A write to the set word turns on every bit written as 1. A write to the clear word turns off every bit written as 1. A status word shows which sources are pending and enabled, so the handler can pick a source itself. To quiet a whole group, software writes a byte of ones, shifted to that group, to the clear word.

Top module: `irq_group_combiner`

## Requirements
- R1: After reset every enable bit is 0, every group output is 0, and the status word reads 0 whatever the source levels are.
- R2: A write to offset 0x0 sets each enable bit whose write-data bit is 1 and leaves every other enable bit as it was. Reads of offset 0x0 return the 32-bit enable vector.
- R3: A write to offset 0x4 clears each enable bit whose write-data bit is 1 and leaves every other enable bit as it was. Reads of offset 0x4 also return the enable vector.
- R4: A read of offset 0xC returns the source levels ANDed bit by bit with the enable vector.
- R5: Group g (0 to 3) covers bits [8g+7:8g] of the source vector and of every register. Its output, bit g of `grp_irq`, is a registered OR of the enabled sources in that byte. It follows a source change at the next rising clock edge, and an enable write at the second rising edge after the write is sampled.
- R6: The group outputs are level-based. An output stays high for as long as an enabled source in its byte stays high, with no further bus access, and it falls one edge after the last such source falls.
- R7: A write to offset 0xC or to any unmapped offset leaves the enable vector unchanged. Reads of unmapped offsets return 0.
- R8: A write of 0xFF shifted left by 8g to offset 0x4 disables exactly group g. The enable bits and the output of every other group are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 4 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| src_level | input | 32 | Raw level of each interrupt source |
| grp_irq | output | 4 | One combined line per group |

## Verification
An enable write and a change of source level can land on the same clock edge. Each reaches the group lines with its own latency: one edge for a source change, two edges for an enable write. The bench provokes this in a sweep. For each pattern it first clears all enables, then sets a pseudo-random enable word and changes the sources in the cycle that follows. It then compares the status word and all four group lines with an AND-and-OR computed in the bench, sampled only after both paths have settled.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
    typedef enum logic [1:0] {
        REG_NONE = 2'd0,
        REG_SET  = 2'd1,
        REG_CLR  = 2'd2,
        REG_STAT = 2'd3
    } irqc_reg_e;
endpackage

// File: rtl/irqc_decode.sv
module irqc_decode
    import irqc_pkg::*;
#(
    parameter int               ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] OFS_SET  = 'h0,
    parameter logic [ADDR_W-1:0] OFS_CLR  = 'h4,
    parameter logic [ADDR_W-1:0] OFS_STAT = 'hC
) (
    input  logic [ADDR_W-1:0] addr,
    output irqc_reg_e         kind
);
    always_comb begin
        if (addr == OFS_SET)       kind = REG_SET;
        else if (addr == OFS_CLR)  kind = REG_CLR;
        else if (addr == OFS_STAT) kind = REG_STAT;
        else                       kind = REG_NONE;
    end
endmodule

// File: rtl/irqc_enable_bank.sv
module irqc_enable_bank #(
    parameter int N_GROUPS = 4,
    parameter int GROUP_W  = 8,
    localparam int SRC_W   = N_GROUPS * GROUP_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_W-1:0] set_mask,
    input  logic [SRC_W-1:0] clr_mask,
    output logic [SRC_W-1:0] en_q
);
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        localparam int LO = g * GROUP_W;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                en_q[LO +: GROUP_W] <= '0;
            end else begin
                // clear takes priority over set on the same bit
                en_q[LO +: GROUP_W] <= (en_q[LO +: GROUP_W] | set_mask[LO +: GROUP_W])
                                       & ~clr_mask[LO +: GROUP_W];
            end
        end
    end
endmodule

// File: rtl/irqc_group_or.sv
module irqc_group_or #(
    parameter int N_GROUPS = 4,
    parameter int GROUP_W  = 8,
    localparam int SRC_W   = N_GROUPS * GROUP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SRC_W-1:0]    pend,
    output logic [N_GROUPS-1:0] irq_q
);
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_or
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q[g] <= 1'b0;
            else        irq_q[g] <= |pend[g*GROUP_W +: GROUP_W];
        end
    end
endmodule

// File: rtl/irq_group_combiner.sv
module irq_group_combiner
    import irqc_pkg::*;
#(
    parameter int N_GROUPS = 4,
    parameter int GROUP_W  = 8,
    parameter int ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] OFS_SET  = 'h0,
    parameter logic [ADDR_W-1:0] OFS_CLR  = 'h4,
    parameter logic [ADDR_W-1:0] OFS_STAT = 'hC,
    localparam int SRC_W = N_GROUPS * GROUP_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_we,
    input  logic [SRC_W-1:0]    bus_wdata,
    output logic [SRC_W-1:0]    bus_rdata,
    input  logic [SRC_W-1:0]    src_level,
    output logic [N_GROUPS-1:0] grp_irq
);
    irqc_reg_e        kind;
    logic [SRC_W-1:0] set_mask;
    logic [SRC_W-1:0] clr_mask;
    logic [SRC_W-1:0] en_vec;
    logic [SRC_W-1:0] pend;

    irqc_decode #(
        .ADDR_W(ADDR_W), .OFS_SET(OFS_SET), .OFS_CLR(OFS_CLR), .OFS_STAT(OFS_STAT)
    ) u_dec (
        .addr(bus_addr),
        .kind(kind)
    );

    assign set_mask = (bus_we && kind == REG_SET) ? bus_wdata : '0;
    assign clr_mask = (bus_we && kind == REG_CLR) ? bus_wdata : '0;

    irqc_enable_bank #(.N_GROUPS(N_GROUPS), .GROUP_W(GROUP_W)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .set_mask(set_mask), .clr_mask(clr_mask),
        .en_q(en_vec)
    );

    assign pend = src_level & en_vec;

    irqc_group_or #(.N_GROUPS(N_GROUPS), .GROUP_W(GROUP_W)) u_or (
        .clk(clk), .rst_n(rst_n),
        .pend(pend),
        .irq_q(grp_irq)
    );

    always_comb begin
        unique case (kind)
            REG_SET, REG_CLR: bus_rdata = en_vec;
            REG_STAT:         bus_rdata = pend;
            default:          bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqc_checker.sv
module irqc_checker #(
    parameter int N_GROUPS = 4,
    parameter int GROUP_W  = 8,
    parameter int ADDR_W   = 4,
    parameter logic [ADDR_W-1:0] OFS_SET  = 'h0,
    parameter logic [ADDR_W-1:0] OFS_CLR  = 'h4,
    parameter logic [ADDR_W-1:0] OFS_STAT = 'hC,
    localparam int SRC_W = N_GROUPS * GROUP_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic [ADDR_W-1:0]   bus_addr,
    input logic                bus_we,
    input logic [SRC_W-1:0]    bus_wdata,
    input logic [SRC_W-1:0]    bus_rdata,
    input logic [SRC_W-1:0]    src_level,
    input logic [N_GROUPS-1:0] grp_irq,
    input logic [SRC_W-1:0]    en_vec
);
    logic [N_GROUPS-1:0] grp_exp;
    logic                mapped;
    logic                en_write;

    always_comb begin
        for (int g = 0; g < N_GROUPS; g++)
            grp_exp[g] = |(src_level[g*GROUP_W +: GROUP_W] & en_vec[g*GROUP_W +: GROUP_W]);
    end
    assign mapped   = (bus_addr == OFS_SET) || (bus_addr == OFS_CLR) || (bus_addr == OFS_STAT);
    assign en_write = bus_we && ((bus_addr == OFS_SET) || (bus_addr == OFS_CLR));

    p_set_takes_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_SET) |=> ((en_vec & $past(bus_wdata)) == $past(bus_wdata)));

    p_clr_takes_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_CLR) |=> ((en_vec & $past(bus_wdata)) == '0));

    p_set_keeps_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == OFS_SET) |=> ((en_vec & ~$past(bus_wdata)) == ($past(en_vec) & ~$past(bus_wdata))));

    p_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == OFS_STAT) |-> (bus_rdata == (src_level & en_vec)));

    p_group_r5: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (grp_irq == $past(grp_exp)));

    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !en_write |=> $stable(en_vec));

    p_unmapped_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> (bus_rdata == '0));
endmodule

bind irq_group_combiner irqc_checker #(
    .N_GROUPS(N_GROUPS), .GROUP_W(GROUP_W), .ADDR_W(ADDR_W),
    .OFS_SET(OFS_SET), .OFS_CLR(OFS_CLR), .OFS_STAT(OFS_STAT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_level(src_level),
    .grp_irq(grp_irq), .en_vec(en_vec)
);

// File: tb/irq_group_combiner_tb.sv
module irq_group_combiner_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] src_level = '0;
    logic [3:0]  grp_irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    irq_group_combiner u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_level(src_level),
        .grp_irq(grp_irq)
    );

    function automatic logic [3:0] exp_grp(input logic [31:0] s, input logic [31:0] e);
        logic [3:0] r;
        for (int g = 0; g < 4; g++) r[g] = |((s & e) >> (8 * g) & 32'hFF);
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        logic [31:0] v;
        logic [31:0] en_m;
        logic [31:0] lf;
        repeat (3) @(negedge clk);
        src_level = 32'hFFFF_FFFF;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        rd(4'h0, v); check("R1 enable", v, 32'h0);
        rd(4'hC, v); check("R1 status", v, 32'h0);
        check("R1 grp", {28'h0, grp_irq}, 32'h0);

        // R2: set, zeros leave bits alone
        wr(4'h0, 32'h0000_0081); en_m = 32'h81;
        wr(4'h0, 32'h0100_0000); en_m |= 32'h0100_0000;
        rd(4'h0, v); check("R2 set readback", v, en_m);
        rd(4'h4, v); check("R3 clr-offset readback", v, en_m);
        @(negedge clk);
        check("R5 grp after set", {28'h0, grp_irq}, {28'h0, exp_grp(src_level, en_m)});

        // R3: clear
        wr(4'h4, 32'h0000_0080); en_m &= ~32'h80;
        rd(4'h0, v); check("R3 clear", v, en_m);

        // R7: status and unmapped writes ignored
        wr(4'hC, 32'hFFFF_FFFF);
        wr(4'h8, 32'hFFFF_FFFF);
        wr(4'h2, 32'hFFFF_FFFF);
        rd(4'h0, v); check("R7 enables unchanged", v, en_m);
        rd(4'h8, v); check("R7 unmapped read", v, 32'h0);
        rd(4'hF, v); check("R7 unmapped read F", v, 32'h0);

        // R5/R4 sweep with enable write and source change in adjacent cycles
        lf = 32'hACE1_1234;
        for (int k = 0; k < 300; k++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            wr(4'h4, 32'hFFFF_FFFF);
            wr(4'h0, lf);
            en_m = lf;
            src_level = {lf[15:0], lf[31:16]} ^ (32'h1 << (k % 32));
            if (k % 4 == 0) src_level &= 32'h0101_0101 << (k % 8);
            @(negedge clk);
            rd(4'hC, v); check("R4 status", v, src_level & en_m);
            check("R5 grp", {28'h0, grp_irq}, {28'h0, exp_grp(src_level, en_m)});
        end

        // R6: level hold, no acknowledge
        wr(4'h4, 32'hFFFF_FFFF);
        wr(4'h0, 32'h0000_2000); en_m = 32'h2000;
        src_level = 32'h0000_2000;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            check("R6 hold", {28'h0, grp_irq}, 32'h2);
        end
        src_level = 32'h0;
        @(negedge clk);
        check("R6 drop", {28'h0, grp_irq}, 32'h0);

        // R8: group clear
        for (int g = 0; g < 4; g++) begin
            wr(4'h0, 32'hFFFF_FFFF);
            src_level = 32'hFFFF_FFFF;
            wr(4'h4, 32'hFF << (8 * g));
            en_m = ~(32'hFF << (8 * g));
            rd(4'h0, v); check("R8 group clear enables", v, en_m);
            @(negedge clk);
            check("R8 group clear outputs", {28'h0, grp_irq}, {28'h0, ~(4'b1 << g)});
        end

        // R1: reset again clears everything
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        rd(4'h4, v); check("R1 enables after reset", v, 32'h0);
        check("R1 grp after reset", {28'h0, grp_irq}, 32'h0);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule